// File: doc/BRIEF.md
# Bit-Split Multi-Pattern Match Engine

This block scans a stream of payload bytes, one per clock cycle, against a fixed set of string patterns. The patterns are divided into groups, and each group is held by one rule module. A rule module contains four tiles. Each tile runs a small table-driven state machine, and that machine sees only two bits of each byte. Because every tile has only four possible input symbols, its table stays small. A pattern is reported only when all four tiles of its module agree. The module's result is therefore the bitwise AND of the four partial-match vectors.

The tables are loaded through a configuration write port before scanning begins. One write fills one table entry of one tile. It names the module, the tile and the state address, and it carries a row of next-state pointers and a partial-match vector. A small controller with two states blocks configuration while bytes are streaming. In state CTL_IDLE, writes are accepted. The transition T_START leads to CTL_SCAN on any valid byte. The transition T_STOP returns to CTL_IDLE on the first cycle without a valid byte. In CTL_SCAN every write is dropped. The match vectors of all modules are joined into one registered output.

Top module: `bsm_engine`

## Requirements
- R1: Tile t of every module (t = 0..3) steps on the byte bits [2t+1:2t] only, and all four tiles step together in the cycle the byte is valid.
- R2: Bit k of a module's vector is 1 exactly when the bytes received since reset end with pattern k of that module's group. This holds for overlapping patterns and for several patterns ending on the same byte.
- R3: The output is NUM_MOD*16 bits wide, and module m occupies bits [16m+15:16m].
- R4: The match vector for a byte appears on the output in the cycle after the clock edge that accepts that byte.
- R5: In a cycle without a valid byte the output is all zeros, and every tile holds its state, so a pattern may span gaps in the stream.
- R6: A configuration write fills the entry of state address cfg_addr in tile cfg_tile of module cfg_mod. In cfg_next, bits [4s+3:4s] hold the next state for 2-bit symbol s. cfg_pmv holds the partial-match vector of that state.
- R7: A write is accepted only while the controller is in CTL_IDLE and no byte is valid in the same cycle. CTL_IDLE is reached one cycle after the last valid byte. Writes at any other time are ignored.
- R8: A synchronous reset returns every tile to state 0 and clears the output. Loaded tables are kept.
- R9: With the group {he, she, his, hers} on bits 0..3 and the input h, x, h, e, only bit 0 is set, and only after the final e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_in | input | 8 | Payload byte |
| byte_valid | input | 1 | byte_in is taken this cycle |
| cfg_we | input | 1 | Configuration write request |
| cfg_mod | input | MOD_W | Target rule module |
| cfg_tile | input | 2 | Target tile within the module |
| cfg_addr | input | STATE_W | Target state entry |
| cfg_next | input | 4*STATE_W | Next-state pointers, one per 2-bit symbol |
| cfg_pmv | input | PMV_W | Partial-match vector of the state |
| match_out | output | NUM_MOD*PMV_W | Concatenated full-match vectors |

## Verification
Every result of this block is due exactly one clock edge after the cycle that produced it. A match, an all-zero idle output and the cleared output after reset all follow that rule. The driver sets the inputs on the falling edge and queues one expected vector for that cycle. The monitor takes one entry five nanoseconds after each rising edge, so each comparison lands on the edge that registers its byte. Configuration effects are checked one cycle later through the bytes that follow the write.

// File: rtl/bsm_pkg.sv
`timescale 1ns/1ps
package bsm_pkg;
    localparam int TILES_PER_MOD = 4;
    localparam int SYM_W         = 2;
    localparam int NUM_SYM       = 1 << SYM_W;

    typedef enum logic [0:0] {
        CTL_IDLE = 1'b0,
        CTL_SCAN = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/bsm_ctrl.sv
`timescale 1ns/1ps
module bsm_ctrl
    import bsm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic byte_valid,
    input  logic cfg_we,
    output logic cfg_accept
);
    ctl_state_e state_q;
    ctl_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= CTL_IDLE;
        else     state_q <= state_d;
    end

    // transitions: T_START (idle -> scan), T_STOP (scan -> idle)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE: if (byte_valid)  state_d = CTL_SCAN;
            CTL_SCAN: if (!byte_valid) state_d = CTL_IDLE;
        endcase
    end

    always_comb begin
        cfg_accept = 1'b0;
        unique case (state_q)
            CTL_IDLE: cfg_accept = cfg_we && !byte_valid;
            CTL_SCAN: cfg_accept = 1'b0;
        endcase
    end

    assert_cfg_gap_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_accept |-> (!byte_valid && !$past(byte_valid)));
endmodule

// File: rtl/bsm_tile.sv
`timescale 1ns/1ps
module bsm_tile
    import bsm_pkg::*;
#(
    parameter int STATE_W = 4,
    parameter int PMV_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       step,
    input  logic [SYM_W-1:0]           sym,
    input  logic                       wr_en,
    input  logic [STATE_W-1:0]         wr_addr,
    input  logic [NUM_SYM*STATE_W-1:0] wr_next,
    input  logic [PMV_W-1:0]           wr_pmv,
    output logic [PMV_W-1:0]           pmv_out
);
    localparam int DEPTH = 1 << STATE_W;
    localparam int ROW_W = NUM_SYM * STATE_W;

    logic [ROW_W-1:0]   next_tab [DEPTH];
    logic [PMV_W-1:0]   pmv_tab  [DEPTH];
    logic [STATE_W-1:0] cur_q;
    logic [STATE_W-1:0] nxt;
    logic [ROW_W-1:0]   row;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            next_tab[wr_addr] <= wr_next;
            pmv_tab[wr_addr]  <= wr_pmv;
        end
    end

    always_comb begin
        row     = next_tab[cur_q];
        nxt     = row[int'(sym)*STATE_W +: STATE_W];
        pmv_out = pmv_tab[nxt];
    end

    always_ff @(posedge clk) begin
        if (rst)       cur_q <= '0;
        else if (step) cur_q <= nxt;
    end

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cur_q));
    assert_reset_home_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cur_q == '0));
endmodule

// File: rtl/bsm_rule_module.sv
`timescale 1ns/1ps
module bsm_rule_module
    import bsm_pkg::*;
#(
    parameter int STATE_W = 4,
    parameter int PMV_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       step,
    input  logic [SYM_W*TILES_PER_MOD-1:0] byte_in,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_tile,
    input  logic [STATE_W-1:0]         wr_addr,
    input  logic [NUM_SYM*STATE_W-1:0] wr_next,
    input  logic [PMV_W-1:0]           wr_pmv,
    output logic [PMV_W-1:0]           full_vec
);
    logic [PMV_W-1:0] pmv [TILES_PER_MOD];

    for (genvar t = 0; t < TILES_PER_MOD; t++) begin : g_tile
        bsm_tile #(.STATE_W(STATE_W), .PMV_W(PMV_W)) u_tile (
            .clk     (clk),
            .rst     (rst),
            .step    (step),
            .sym     (byte_in[SYM_W*t +: SYM_W]),
            .wr_en   (wr_en && (wr_tile == 2'(t))),
            .wr_addr (wr_addr),
            .wr_next (wr_next),
            .wr_pmv  (wr_pmv),
            .pmv_out (pmv[t])
        );
    end

    always_comb begin
        full_vec = '1;
        for (int t = 0; t < TILES_PER_MOD; t++) full_vec = full_vec & pmv[t];
    end
endmodule

// File: rtl/bsm_engine.sv
`timescale 1ns/1ps
module bsm_engine
    import bsm_pkg::*;
#(
    parameter int NUM_MOD = 2,
    parameter int STATE_W = 4,
    parameter int PMV_W   = 16,
    localparam int MOD_W  = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1,
    localparam int OUT_W  = NUM_MOD * PMV_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [7:0]                 byte_in,
    input  logic                       byte_valid,
    input  logic                       cfg_we,
    input  logic [MOD_W-1:0]           cfg_mod,
    input  logic [1:0]                 cfg_tile,
    input  logic [STATE_W-1:0]         cfg_addr,
    input  logic [NUM_SYM*STATE_W-1:0] cfg_next,
    input  logic [PMV_W-1:0]           cfg_pmv,
    output logic [OUT_W-1:0]           match_out
);
    logic             cfg_accept;
    logic [OUT_W-1:0] all_vec;
    logic [OUT_W-1:0] match_q;

    bsm_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .cfg_we     (cfg_we),
        .cfg_accept (cfg_accept)
    );

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
        bsm_rule_module #(.STATE_W(STATE_W), .PMV_W(PMV_W)) u_mod (
            .clk      (clk),
            .rst      (rst),
            .step     (byte_valid),
            .byte_in  (byte_in),
            .wr_en    (cfg_accept && (cfg_mod == MOD_W'(m))),
            .wr_tile  (cfg_tile),
            .wr_addr  (cfg_addr),
            .wr_next  (cfg_next),
            .wr_pmv   (cfg_pmv),
            .full_vec (all_vec[m*PMV_W +: PMV_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)             match_q <= '0;
        else if (byte_valid) match_q <= all_vec;
        else                 match_q <= '0;
    end

    assign match_out = match_q;

    assert_match_after_byte_R4: assert property (@(posedge clk) disable iff (rst)
        (match_out != '0) |-> $past(byte_valid));
endmodule

// File: tb/bsm_engine_tb.sv
`timescale 1ns/1ps
module bsm_engine_tb;
    localparam int NM = 2;
    localparam int PW = 16;
    localparam int SW = 4;
    localparam int OW = NM * PW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    byte_in = '0;
    logic          byte_valid = 1'b0;
    logic          cfg_we = 1'b0;
    logic [0:0]    cfg_mod = '0;
    logic [1:0]    cfg_tile = '0;
    logic [SW-1:0] cfg_addr = '0;
    logic [4*SW-1:0] cfg_next = '0;
    logic [PW-1:0] cfg_pmv = '0;
    logic [OW-1:0] match_out;

    always #10 clk = ~clk;

    bsm_engine #(.NUM_MOD(NM), .STATE_W(SW), .PMV_W(PW)) u_dut (
        .clk(clk), .rst(rst), .byte_in(byte_in), .byte_valid(byte_valid),
        .cfg_we(cfg_we), .cfg_mod(cfg_mod), .cfg_tile(cfg_tile),
        .cfg_addr(cfg_addr), .cfg_next(cfg_next), .cfg_pmv(cfg_pmv),
        .match_out(match_out)
    );

    string pats [NM][4];
    int    npat [NM];
    logic [7:0] hist [4];
    int    hcnt = 0;
    bit    mod1_off = 1'b0;
    logic [OW-1:0] exp_q [$];
    string tag_q [$];
    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;

    function automatic int psym(int m, int k, int i, int t);
        return (int'(pats[m][k][i]) >> (2*t)) & 3;
    endfunction

    task automatic cfg_write(int m, int t, int a, logic [4*SW-1:0] nx, logic [PW-1:0] pv);
        @(negedge clk);
        cfg_mod = 1'(m); cfg_tile = 2'(t); cfg_addr = SW'(a);
        cfg_next = nx; cfg_pmv = pv; cfg_we = 1'b1;
    endtask

    // builds the 2-bit projected automaton of group m for tile t and loads it (R6)
    task automatic config_tile(int m, int t);
        int sk [16];
        int sl [16];
        int ns;
        ns = 1; sk[0] = 0; sl[0] = 0;
        for (int k = 0; k < npat[m]; k++) begin
            for (int l = 1; l <= pats[m][k].len(); l++) begin
                bit found;
                found = 1'b0;
                for (int q = 1; q < ns; q++) begin
                    if (sl[q] == l) begin
                        bit eq;
                        eq = 1'b1;
                        for (int i = 0; i < l; i++)
                            if (psym(m, sk[q], i, t) != psym(m, k, i, t)) eq = 1'b0;
                        if (eq) found = 1'b1;
                    end
                end
                if (!found) begin sk[ns] = k; sl[ns] = l; ns++; end
            end
        end
        for (int s = 0; s < 16; s++) begin
            logic [4*SW-1:0] nx;
            logic [PW-1:0]   pv;
            nx = '0; pv = '0;
            if (s < ns) begin
                int len_s;
                len_s = sl[s];
                for (int a = 0; a < 4; a++) begin
                    int best;
                    bit got;
                    best = 0; got = 1'b0;
                    for (int ml = len_s + 1; ml >= 1 && !got; ml--) begin
                        for (int q = 1; q < ns && !got; q++) begin
                            if (sl[q] == ml) begin
                                bit eq;
                                eq = 1'b1;
                                for (int i = 0; i < ml; i++) begin
                                    int j;
                                    int cj;
                                    j = len_s + 1 - ml + i;
                                    cj = (j < len_s) ? psym(m, sk[s], j, t) : a;
                                    if (psym(m, sk[q], i, t) != cj) eq = 1'b0;
                                end
                                if (eq) begin best = q; got = 1'b1; end
                            end
                        end
                    end
                    nx[a*SW +: SW] = SW'(best);
                end
                for (int k = 0; k < npat[m]; k++) begin
                    int lk;
                    lk = pats[m][k].len();
                    if (lk <= len_s) begin
                        bit eq;
                        eq = 1'b1;
                        for (int i = 0; i < lk; i++)
                            if (psym(m, k, i, t) != psym(m, sk[s], len_s - lk + i, t)) eq = 1'b0;
                        if (eq) pv[k] = 1'b1;
                    end
                end
            end
            cfg_write(m, t, s, nx, pv);
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [OW-1:0] ref_vec();
        logic [OW-1:0] e;
        e = '0;
        for (int m = 0; m < NM; m++) begin
            if (!(m == 1 && mod1_off)) begin
                for (int k = 0; k < npat[m]; k++) begin
                    int len_k;
                    len_k = pats[m][k].len();
                    if (hcnt >= len_k) begin
                        bit eq;
                        eq = 1'b1;
                        for (int i = 0; i < len_k; i++)
                            if (pats[m][k][i] != hist[len_k-1-i]) eq = 1'b0;
                        if (eq) e[m*PW + k] = 1'b1;
                    end
                end
            end
        end
        return e;
    endfunction

    // driver: one cycle of stimulus, expected result queued for the next edge
    task automatic drive(bit v, logic [7:0] b, bit r, bit we, string tag);
        logic [OW-1:0] e;
        @(negedge clk);
        byte_valid = v; byte_in = b; rst = r; cfg_we = we;
        if (r) begin
            hcnt = 0; e = '0;
        end else if (v) begin
            hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = b;
            hcnt++;
            e = ref_vec();
        end else begin
            e = '0;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic send(string s, string tag);
        for (int i = 0; i < s.len(); i++) drive(1'b1, s[i], 1'b0, 1'b0, tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    // monitor: compares one queued item per rising edge
    always @(posedge clk) begin
        #5;
        if (!finished && exp_q.size() > 0) begin
            logic [OW-1:0] e;
            string tg;
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            total++;
            if (match_out !== e) begin
                bad++;
                $display("FAIL %s: got %h expected %h", tg, match_out, e);
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        pats[0][0] = "he";  pats[0][1] = "she"; pats[0][2] = "his"; pats[0][3] = "hers";
        npat[0] = 4;
        pats[1][0] = "hi";  pats[1][1] = "e";   pats[1][2] = "abca"; pats[1][3] = "";
        npat[1] = 3;
        for (int i = 0; i < 4; i++) hist[i] = '0;

        drive(1'b0, 8'h00, 1'b1, 1'b0, "R8 reset state");
        drive(1'b0, 8'h00, 1'b1, 1'b0, "R8 reset state");
        idle(1, "R8 after reset");

        for (int m = 0; m < NM; m++)
            for (int t = 0; t < 4; t++) config_tile(m, t);

        send("hxhe", "R9 he only at final e");
        idle(2, "R5 idle zeros");
        drive(1'b0, 8'h00, 1'b1, 1'b0, "R8 reset");
        send("ushers", "R2 overlapping she/he/hers");
        idle(1, "R5 idle zeros");

        drive(1'b1, "s", 1'b0, 1'b0, "R5 gap");
        idle(2, "R5 gap holds state");
        drive(1'b1, "h", 1'b0, 1'b0, "R5 gap");
        idle(1, "R5 gap holds state");
        drive(1'b1, "e", 1'b0, 1'b0, "R5 she across gaps");

        send("abcabca", "R3 upper module bits");
        send("hishi", "R1 bit-pair routing his/hi");

        send("h", "R8 before reset");
        drive(1'b0, 8'h00, 1'b1, 1'b0, "R8 reset mid-pattern");
        send("e", "R8 no he after reset");
        send("he", "R8 tables kept");

        // write that would clear module 1 tile 0 root row
        cfg_mod = 1'b1; cfg_tile = 2'd0; cfg_addr = '0; cfg_next = '0; cfg_pmv = '0;
        drive(1'b1, "x", 1'b0, 1'b1, "R7 write with byte ignored");
        drive(1'b0, 8'h00, 1'b0, 1'b1, "R7 write in scan ignored");
        drive(1'b1, "e", 1'b0, 1'b0, "R7 module 1 intact");
        idle(2, "R7 idle");
        drive(1'b0, 8'h00, 1'b0, 1'b1, "R7 write accepted in idle");
        mod1_off = 1'b1;
        drive(1'b0, 8'h00, 1'b1, 1'b0, "R8 reset");
        send("hehie", "R6 R7 rewritten row silences module 1");
        idle(1, "R7 idle");
        config_tile(1, 0);
        mod1_off = 1'b0;
        drive(1'b0, 8'h00, 1'b1, 1'b0, "R8 reset");
        send("hie", "R6 row restored");

        for (int i = 0; i < 400; i++) begin
            string cs;
            cs = "hesirxabc";
            if ($urandom_range(0, 9) < 7)
                drive(1'b1, cs[$urandom_range(0, 8)], 1'b0, 1'b0, "R2 random stream");
            else
                drive(1'b0, 8'h00, 1'b0, 1'b0, "R5 random gap");
        end
        idle(3, "R5 final idle");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule